// File: doc/BRIEF.md
# PHY Control Register Bank with Per-Bit Write Enables

This block holds the control word set for a storage-interface PHY: seven 32-bit control registers plus one read-only status word, all reached over a minimal single-master bus made of an address, a write-data word, a write strobe and a read-data word. Every write carries its own enable mask. The upper sixteen bits of the written word are not stored. Instead, bit `x+16` allows bit `x` of the lower half to change. Software can therefore flip one field, such as the DLL enable, without first reading the register back.

The block turns the relevant control fields into named outputs that drive the analog side of the PHY: power-up, DLL enable, drive strength, DLL frequency band, and the output tap-delay enable and select. It also hands the live calibration-done and DLL-ready indications back to software through the status word. Read data is registered and appears one cycle after the address is presented. Control outputs come straight from the storage flops.

Top module: `phy_ctl_regbank`

## Requirements
- R1: While reset is asserted, every control bit is 0. As a result, `pwr_on`, `dll_en`, `drv_str`, `freq_sel`, `otap_en`, `otap_sel` and `bus_rdata` are all 0, so the PHY starts powered down with the DLL off.
- R2: A write to a control register changes its bit x (0..15) to `bus_wdata[x]` only when `bus_wdata[x+16]` is 1. Every other bit keeps its value.
- R3: Reading a control register returns 0 in bits 31:16, whatever was written there.
- R4: The control registers sit at word-aligned byte offsets 0x00 through 0x18, and each one holds its own value. `bus_rdata` shows the value addressed at a clock edge from that edge on, so the read data is one cycle behind the address.
- R5: The register at 0x18 drives `pwr_on` from bit 0 (1 = powered), `dll_en` from bit 1 and `drv_str` from bits 6:4. The drive codes are 0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm and 4 = 40 ohm. The outputs change at the edge that takes the write.
- R6: The register at 0x00 drives `freq_sel` from bits 13:12, `otap_en` from bit 11 and `otap_sel` from bits 10:7. The outputs change at the edge that takes the write.
- R7: Reading offset 0x20 returns `stat_cal_done` in bit 6 and `stat_dll_ready` in bit 5, sampled at the capturing edge. All other bits read as 0.
- R8: Writes to 0x20, to offsets that are not word aligned, or to any offset outside the map change no register. Reads of such offsets return 0.
- R9: A write whose upper sixteen bits are all 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data: bits 31:16 are enables, bits 15:0 are values |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| stat_cal_done | input | 1 | Live calibration-done indication |
| stat_dll_ready | input | 1 | Live DLL-lock indication |
| pwr_on | output | 1 | PHY power-up (1 = powered) |
| dll_en | output | 1 | DLL enable |
| drv_str | output | 3 | Drive-strength code |
| freq_sel | output | 2 | DLL frequency band select |
| otap_en | output | 1 | Output tap-delay enable |
| otap_sel | output | 4 | Output tap-delay select |

## Verification
A write presented before clock edge N shows up on the decoded PHY outputs just after edge N, so the bench checks the port fields at the falling edge that follows. Read data is captured at the edge where its address is present. The driver therefore queues the expected word when it drives the address, and the monitor pops and compares it 1 ns after that rising edge, before anything else moves. Status bits are sampled on the same edge as the address, so the bench changes the status inputs together with the address and computes the expectation from those values.

// File: rtl/phyreg_pkg.sv
`timescale 1ns/1ps
package phyreg_pkg;
   // power/DLL register field positions
   localparam int PWR_BIT     = 0;
   localparam int DLL_BIT     = 1;
   localparam int DRV_LSB     = 4;
   localparam int DRV_W       = 3;
   // DLL band / tap-delay register field positions
   localparam int OTSEL_LSB   = 7;
   localparam int OTSEL_W     = 4;
   localparam int OTEN_BIT    = 11;
   localparam int FSEL_LSB    = 12;
   localparam int FSEL_W      = 2;
   // status word bit positions
   localparam int DLLRDY_BIT  = 5;
   localparam int CAL_BIT     = 6;
   // highest control bit any decoded field needs
   localparam int FIELD_TOP   = FSEL_LSB + FSEL_W;
endpackage

// File: rtl/phyreg_masked_reg.sv
`timescale 1ns/1ps
module phyreg_masked_reg #(
   parameter int             W       = 16,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_val,
   input  logic [W-1:0] wr_mask,
   output logic [W-1:0] q
);
   // one flop per bit, each with its own enable from the mask
   for (genvar b = 0; b < W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= RST_VAL[b];
         else if (wr_en && wr_mask[b])
            bit_q <= wr_val[b];
      end
      assign q[b] = bit_q;
   end
endmodule

// File: rtl/phyreg_decode.sv
`timescale 1ns/1ps
module phyreg_decode #(
   parameter int ADDR_W    = 8,
   parameter int NUM_CTL   = 7,
   parameter int STAT_WORD = 8,
   parameter int IDX_W     = 3
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic               we,
   output logic [NUM_CTL-1:0] wr_sel,
   output logic [IDX_W-1:0]   ctl_idx,
   output logic               ctl_hit,
   output logic               stat_hit
);
   localparam int WORD_W = ADDR_W - 2;

   logic              aligned;
   logic [WORD_W-1:0] word;

   assign aligned  = (addr[1:0] == 2'b00);
   assign word     = addr[ADDR_W-1:2];
   assign ctl_hit  = aligned && (word < WORD_W'(NUM_CTL));
   assign stat_hit = aligned && (word == WORD_W'(STAT_WORD));
   assign ctl_idx  = word[IDX_W-1:0];

   for (genvar i = 0; i < NUM_CTL; i++) begin : g_sel
      assign wr_sel[i] = we && aligned && (word == WORD_W'(i));
   end
endmodule

// File: rtl/phyreg_rdmux.sv
`timescale 1ns/1ps
module phyreg_rdmux #(
   parameter int DATA_W  = 32,
   parameter int HALF    = 16,
   parameter int NUM_CTL = 7,
   parameter int IDX_W   = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CTL*HALF-1:0] ctl_flat,
   input  logic [IDX_W-1:0]        ctl_idx,
   input  logic                    ctl_hit,
   input  logic                    stat_hit,
   input  logic [HALF-1:0]         stat_word,
   output logic [DATA_W-1:0]       rdata
);
   logic [HALF-1:0]   sel;
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM_CTL; i++) begin
         if (ctl_idx == IDX_W'(i))
            sel = ctl_flat[i*HALF +: HALF];
      end
   end

   // upper half is never stored, so it is zero-filled here
   always_comb begin
      if (ctl_hit)
         rd_next = DATA_W'(sel);
      else if (stat_hit)
         rd_next = DATA_W'(stat_word);
      else
         rd_next = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else
         rdata <= rd_next;
   end
endmodule

// File: rtl/phy_ctl_regbank.sv
`timescale 1ns/1ps
module phy_ctl_regbank
   import phyreg_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int NUM_CTL     = 7,
   parameter int STAT_OFFSET = 32,
   parameter int FREQ_REG    = 0,
   parameter int PWR_REG     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              stat_cal_done,
   input  logic              stat_dll_ready,
   output logic              pwr_on,
   output logic              dll_en,
   output logic [DRV_W-1:0]  drv_str,
   output logic [FSEL_W-1:0] freq_sel,
   output logic              otap_en,
   output logic [OTSEL_W-1:0] otap_sel
);
   localparam int HALF      = DATA_W / 2;
   localparam int IDX_W     = (NUM_CTL > 1) ? $clog2(NUM_CTL) : 1;
   localparam int STAT_WORD = STAT_OFFSET / 4;

   // elaboration-time parameter checks
   if (DATA_W != 2 * HALF) begin : g_bad_width
      $error("DATA_W must be even");
   end
   if (HALF < FIELD_TOP) begin : g_bad_half
      $error("lower half too narrow for the decoded fields");
   end
   if (NUM_CTL < 2) begin : g_bad_count
      $error("NUM_CTL must be at least 2");
   end
   if ((STAT_OFFSET % 4) != 0 || STAT_WORD < NUM_CTL) begin : g_bad_stat
      $error("status offset must be word aligned and above the control words");
   end
   if (STAT_OFFSET >= (1 << ADDR_W)) begin : g_bad_addr
      $error("status offset outside the address space");
   end
   if (FREQ_REG >= NUM_CTL || PWR_REG >= NUM_CTL || FREQ_REG == PWR_REG) begin : g_bad_map
      $error("field registers must be distinct and inside the bank");
   end

   logic [NUM_CTL-1:0]      wr_sel;
   logic [IDX_W-1:0]        ctl_idx;
   logic                    ctl_hit;
   logic                    stat_hit;
   logic [HALF-1:0]         ctl_q [NUM_CTL];
   logic [NUM_CTL*HALF-1:0] ctl_flat;
   logic [HALF-1:0]         stat_word;

   phyreg_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_CTL   (NUM_CTL),
      .STAT_WORD (STAT_WORD),
      .IDX_W     (IDX_W)
   ) i_decode (
      .addr     (bus_addr),
      .we       (bus_we),
      .wr_sel   (wr_sel),
      .ctl_idx  (ctl_idx),
      .ctl_hit  (ctl_hit),
      .stat_hit (stat_hit)
   );

   for (genvar r = 0; r < NUM_CTL; r++) begin : g_reg
      phyreg_masked_reg #(
         .W       (HALF),
         .RST_VAL ('0)
      ) i_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_sel[r]),
         .wr_val  (bus_wdata[HALF-1:0]),
         .wr_mask (bus_wdata[DATA_W-1:HALF]),
         .q       (ctl_q[r])
      );
      assign ctl_flat[r*HALF +: HALF] = ctl_q[r];
   end

   always_comb begin
      stat_word             = '0;
      stat_word[CAL_BIT]    = stat_cal_done;
      stat_word[DLLRDY_BIT] = stat_dll_ready;
   end

   phyreg_rdmux #(
      .DATA_W  (DATA_W),
      .HALF    (HALF),
      .NUM_CTL (NUM_CTL),
      .IDX_W   (IDX_W)
   ) i_rdmux (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_flat  (ctl_flat),
      .ctl_idx   (ctl_idx),
      .ctl_hit   (ctl_hit),
      .stat_hit  (stat_hit),
      .stat_word (stat_word),
      .rdata     (bus_rdata)
   );

   // decoded PHY control fields
   assign pwr_on   = ctl_q[PWR_REG][PWR_BIT];
   assign dll_en   = ctl_q[PWR_REG][DLL_BIT];
   assign drv_str  = ctl_q[PWR_REG][DRV_LSB +: DRV_W];
   assign freq_sel = ctl_q[FREQ_REG][FSEL_LSB +: FSEL_W];
   assign otap_en  = ctl_q[FREQ_REG][OTEN_BIT];
   assign otap_sel = ctl_q[FREQ_REG][OTSEL_LSB +: OTSEL_W];
endmodule

// File: rtl/phyreg_checker.sv
`timescale 1ns/1ps
module phyreg_checker
   import phyreg_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int NUM_CTL     = 7,
   parameter int STAT_OFFSET = 32,
   parameter int FREQ_REG    = 0,
   parameter int PWR_REG     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              stat_cal_done,
   input logic              stat_dll_ready,
   input logic              pwr_on,
   input logic              dll_en,
   input logic [DRV_W-1:0]  drv_str,
   input logic [FSEL_W-1:0] freq_sel,
   input logic              otap_en,
   input logic [OTSEL_W-1:0] otap_sel
);
   localparam int HALF = DATA_W / 2;
   localparam logic [ADDR_W-1:0] PWR_ADDR  = ADDR_W'(PWR_REG * 4);
   localparam logic [ADDR_W-1:0] FREQ_ADDR = ADDR_W'(FREQ_REG * 4);
   localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFFSET);

   logic ctl_mapped;
   logic any_mapped;
   assign ctl_mapped = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:2] < (ADDR_W-2)'(NUM_CTL));
   assign any_mapped = ctl_mapped || (bus_addr == STAT_ADDR);

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (bus_rdata == '0 && !pwr_on && !dll_en && drv_str == '0 &&
                  freq_sel == '0 && !otap_en && otap_sel == '0)); // R1

   AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == PWR_ADDR && bus_wdata[HALF + PWR_BIT]) |=> $stable(pwr_on)); // R2

   AST_MASK_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == PWR_ADDR && bus_wdata[HALF + DLL_BIT]) |=>
      dll_en == $past(bus_wdata[DLL_BIT])); // R5

   AST_FREQ_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == FREQ_ADDR && bus_wdata[HALF + FSEL_LSB +: FSEL_W] == '1) |=>
      freq_sel == $past(bus_wdata[FSEL_LSB +: FSEL_W])); // R6

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_mapped |=> bus_rdata[DATA_W-1:HALF] == '0); // R3

   AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == STAT_ADDR) |=>
      (bus_rdata[CAL_BIT] == $past(stat_cal_done) &&
       bus_rdata[DLLRDY_BIT] == $past(stat_dll_ready) &&
       $countones(bus_rdata) == 32'($past(stat_cal_done)) + 32'($past(stat_dll_ready)))); // R7

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !any_mapped |=> bus_rdata == '0); // R8

   AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == STAT_ADDR) |=>
      ($stable(drv_str) && $stable(otap_sel) && $stable(pwr_on))); // R8
endmodule

bind phy_ctl_regbank phyreg_checker #(
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .NUM_CTL     (NUM_CTL),
   .STAT_OFFSET (STAT_OFFSET),
   .FREQ_REG    (FREQ_REG),
   .PWR_REG     (PWR_REG)
) i_phyreg_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_addr       (bus_addr),
   .bus_wdata      (bus_wdata),
   .bus_we         (bus_we),
   .bus_rdata      (bus_rdata),
   .stat_cal_done  (stat_cal_done),
   .stat_dll_ready (stat_dll_ready),
   .pwr_on         (pwr_on),
   .dll_en         (dll_en),
   .drv_str        (drv_str),
   .freq_sel       (freq_sel),
   .otap_en        (otap_en),
   .otap_sel       (otap_sel)
);

// File: tb/test_phy_ctl_regbank.sv
`timescale 1ns/1ps
module test_phy_ctl_regbank;
   localparam int NUM_CTL = 7;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  addr;
   logic [31:0] wdata;
   logic        we;
   logic [31:0] rdata;
   logic        cal_in;
   logic        dll_in;
   logic        pwr_on, dll_en, otap_en;
   logic [2:0]  drv_str;
   logic [1:0]  freq_sel;
   logic [3:0]  otap_sel;

   always #2.5 clk = ~clk;

   phy_ctl_regbank i_phy_ctl_regbank (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
      .bus_rdata(rdata), .stat_cal_done(cal_in), .stat_dll_ready(dll_in),
      .pwr_on(pwr_on), .dll_en(dll_en), .drv_str(drv_str), .freq_sel(freq_sel),
      .otap_en(otap_en), .otap_sel(otap_sel)
   );

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } exp_t;

   exp_t        sbq[$];
   int          n_chk  = 0;
   int          n_fail = 0;
   logic [15:0] mdl [NUM_CTL];

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(logic [7:0] a);
      if (a[1:0] == 2'b00 && a[7:2] < 6'(NUM_CTL))
         return {16'h0000, mdl[a[7:2]]};
      else if (a == 8'h20)
         return (32'(cal_in) << 6) | (32'(dll_in) << 5);
      else
         return 32'h0;
   endfunction

   // driver: one masked write, then bus goes idle on the next falling edge
   task automatic bus_wr(logic [7:0] a, logic [15:0] mask, logic [15:0] val);
      @(negedge clk);
      addr  = a;
      wdata = {mask, val};
      we    = 1'b1;
      if (a[1:0] == 2'b00 && a[7:2] < 6'(NUM_CTL))
         mdl[a[7:2]] = (mdl[a[7:2]] & ~mask) | (val & mask);
      @(negedge clk);
      we    = 1'b0;
      addr  = 8'hFC;
      wdata = 32'h0;
   endtask

   // driver: present a read address and queue its expected word
   task automatic bus_rd(logic [7:0] a, logic c, logic d, string tag);
      @(negedge clk);
      addr   = a;
      we     = 1'b0;
      cal_in = c;
      dll_in = d;
      sbq.push_back('{exp_read(a), tag});
   endtask

   task automatic check_ports(string tag);
      check({tag, " pwr_on"},   32'(pwr_on),   32'(mdl[6][0]));
      check({tag, " dll_en"},   32'(dll_en),   32'(mdl[6][1]));
      check({tag, " drv_str"},  32'(drv_str),  32'(mdl[6][6:4]));
      check({tag, " freq_sel"}, 32'(freq_sel), 32'(mdl[0][13:12]));
      check({tag, " otap_en"},  32'(otap_en),  32'(mdl[0][11]));
      check({tag, " otap_sel"}, 32'(otap_sel), 32'(mdl[0][10:7]));
   endtask

   // monitor: compare read data just after the capturing edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check(e.tag, rdata, e.exp);
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n  = 1'b0;
      addr   = 8'hFC;
      wdata  = 32'h0;
      we     = 1'b0;
      cal_in = 1'b0;
      dll_in = 1'b0;
      for (int i = 0; i < NUM_CTL; i++) mdl[i] = 16'h0000;
      repeat (3) @(negedge clk);
      check_ports("R1 in reset");
      check("R1 rdata in reset", rdata, 32'h0);
      rst_n = 1'b1;
      for (int i = 0; i < NUM_CTL; i++) bus_rd(8'(i * 4), 1'b0, 1'b0, "R1 reset value");

      // R5: power bit alone, then DLL bit with every value bit set
      bus_wr(8'h18, 16'h0001, 16'h0001);
      check_ports("R5 power up");
      bus_wr(8'h18, 16'h0002, 16'hFFFF);
      check_ports("R2 single-bit enable");
      bus_rd(8'h18, 1'b0, 1'b0, "R2 readback 0x18");

      // R5: each drive-strength code
      for (int c = 0; c < 5; c++) begin
         bus_wr(8'h18, 16'h0070, 16'(c << 4));
         check("R5 drv_str code", 32'(drv_str), 32'(c));
         check_ports("R5 neighbours");
      end

      // R6: band, tap enable and tap select, field by field
      bus_wr(8'h00, 16'h3000, 16'h2000);
      bus_wr(8'h00, 16'h0800, 16'h0800);
      bus_wr(8'h00, 16'h0780, 16'h0200);
      check_ports("R6 fields");
      check("R6 otap_sel", 32'(otap_sel), 32'h4);
      bus_rd(8'h00, 1'b0, 1'b0, "R6 readback 0x00");

      // R4/R3: full writes of distinct patterns to every register
      for (int i = 0; i < NUM_CTL; i++)
         bus_wr(8'(i * 4), 16'hFFFF, 16'hA5C3 ^ 16'(i * 16'h1111));
      check_ports("R4 after full writes");
      for (int i = 0; i < NUM_CTL; i++) bus_rd(8'(i * 4), 1'b0, 1'b0, "R4 R3 readback");

      // R9: empty mask
      bus_wr(8'h18, 16'h0000, 16'h0000);
      bus_wr(8'h00, 16'h0000, 16'hFFFF);
      bus_wr(8'h0C, 16'h0000, 16'h5A5A);
      check_ports("R9 empty mask");
      bus_rd(8'h0C, 1'b0, 1'b0, "R9 readback 0x0C");

      // R2: partial nibble
      bus_wr(8'h08, 16'h00F0, 16'h1234);
      bus_rd(8'h08, 1'b0, 1'b0, "R2 partial 0x08");

      // R7: every status combination
      bus_rd(8'h20, 1'b0, 1'b0, "R7 status 00");
      bus_rd(8'h20, 1'b1, 1'b0, "R7 status cal");
      bus_rd(8'h20, 1'b0, 1'b1, "R7 status dll");
      bus_rd(8'h20, 1'b1, 1'b1, "R7 status both");

      // R8: ignored writes
      bus_wr(8'h20, 16'hFFFF, 16'hFFFF);
      bus_wr(8'h1C, 16'hFFFF, 16'hFFFF);
      bus_wr(8'h24, 16'hFFFF, 16'hFFFF);
      bus_wr(8'h1A, 16'hFFFF, 16'h0000);
      bus_wr(8'h02, 16'hFFFF, 16'h0000);
      check_ports("R8 after ignored writes");
      for (int i = 0; i < NUM_CTL; i++) bus_rd(8'(i * 4), 1'b0, 1'b0, "R8 registers intact");
      bus_rd(8'h20, 1'b1, 1'b0, "R8 status after write");
      bus_rd(8'h1C, 1'b1, 1'b1, "R8 unmapped 0x1C");
      bus_rd(8'h24, 1'b0, 1'b0, "R8 unmapped 0x24");
      bus_rd(8'h02, 1'b0, 1'b0, "R8 unaligned 0x02");
      bus_rd(8'h40, 1'b0, 1'b0, "R8 unmapped 0x40");

      @(negedge clk);
      addr = 8'hFC;
      while (sbq.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule